// File: doc/BRIEF.md
# Stack-Based Instruction Sequencer Core

A small multi-cycle processor core that steps through a fixed set of variable-length byte instructions. Each instruction is fetched, decoded, executed and written back in turn. It keeps a program counter and eight 64-bit general registers. Register 4 serves as the stack pointer. A single byte-addressed memory port carries instruction fetches, stack traffic and register stores.

The instruction set covers push, pop, register-to-register move, register-to-memory store, relative call and return. Call and return move the program counter through memory, so the next program counter comes from the instruction length, a signed displacement or a word popped from the stack. Any other encoding stops the core: the `halted` output goes high and the program counter holds its value until reset.

Every memory transfer is one 64-bit word with a request/ready handshake. A fetch reads the eight bytes starting at the program counter. Stack and store data are 64-bit words, least significant byte at the lowest address.

Top module: `stk_core`

## Requirements
- R1: While reset is asserted, `halted` is 0 and `cur_pc` equals RESET_PC. After reset the stack pointer (register 4) holds RESET_SP and every other register holds zero.
- R2: Every instruction begins with a read whose address is the program counter. The returned word holds the bytes at PC..PC+7 with byte PC in bits 7:0, and bits 7:0 are the first instruction byte.
- R3: Byte 0x50+r (r in 0..7) is a one-byte push. It writes register r to address SP-8, lowers SP by 8 and advances the PC by 1. When r is 4, the value written is SP before the decrement.
- R4: Byte 0x58+r is a one-byte pop. It reads the word at SP into register r, raises SP by 8 and advances the PC by 1. When r is 4, register 4 ends up holding the loaded word, not SP+8.
- R5: Bytes 0x48 0x89 m with m[7:6]=11 form a three-byte register move. It copies register m[5:3] into register m[2:0], makes no data access and advances the PC by 3.
- R6: Bytes 0x48 0x89 m with m[7:6]=00 form a three-byte store. It writes register m[5:3] to the address held in register m[2:0] and advances the PC by 3.
- R7: Byte 0xE8 followed by a 32-bit little-endian signed displacement is a five-byte call. It writes PC+5 (zero-extended) to SP-8, lowers SP by 8, and sets PC to PC+5+displacement, wrapping modulo 2^ADDR_W.
- R8: Byte 0xC3 is a return. It reads the word at SP, loads its low ADDR_W bits into the PC and raises SP by 8.
- R9: Any other first byte, a 0x48 not followed by 0x89, or a mode field of 01 or 10 is illegal. The core raises `halted`, issues no further memory request and keeps `cur_pc` at the illegal instruction's address.
- R10: A request stays asserted, with address, write enable and write data unchanged, until the cycle in which `mem_ready` is high; any number of wait cycles is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 64-bit word |
| mem_wdata | output | DATA_W | Write data, least significant byte at lowest address |
| mem_rdata | input | DATA_W | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Transfer completes in this cycle |
| cur_pc | output | ADDR_W | Current program counter |
| halted | output | 1 | Core stopped on an illegal instruction |

## Verification
The bench targets the cases where stack-pointer and destination updates collide. On a push of register 4, a core that stored the decremented value would put the wrong word on the bus. On a pop into register 4, a core that let the increment win would later push the stale stack address. Calls are exercised with forward, backward and wrapping displacements, nested two deep. A sign-extension or return-address error would send the next fetch to the wrong place. Each illegal-encoding form (bad first byte, bad second byte, bad mode field) must stop the bus and freeze the PC. Varying wait states check that a request is never dropped or altered while it waits for `mem_ready`.

// File: rtl/stk_core_pkg.sv
package stk_core_pkg;

   typedef enum logic [2:0] {
      OP_PUSH,
      OP_POP,
      OP_MOVR,
      OP_STORE,
      OP_CALL,
      OP_RET,
      OP_ILL
   } op_e;

   typedef struct packed {
      op_e         op;
      logic [2:0]  src;
      logic [2:0]  dst;
      logic [2:0]  len;
      logic [31:0] disp;
   } dec_t;

   typedef enum logic [2:0] {
      S_FETCH,
      S_DEC,
      S_EXEC,
      S_WB,
      S_HALT
   } st_e;

   localparam logic [7:0] BYTE_WIDE  = 8'h48;
   localparam logic [7:0] BYTE_MOV   = 8'h89;
   localparam logic [7:0] BYTE_CALL  = 8'hE8;
   localparam logic [7:0] BYTE_RET   = 8'hC3;
   localparam logic [4:0] GRP_PUSH   = 5'b01010;
   localparam logic [4:0] GRP_POP    = 5'b01011;
   localparam int         IR_W       = 40;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
   import stk_core_pkg::*;
(
   input  logic [IR_W-1:0] win,
   output dec_t            dec
);

   logic [7:0] b0, b1, b2;

   assign b0 = win[7:0];
   assign b1 = win[15:8];
   assign b2 = win[23:16];

   always_comb begin
      dec      = '0;
      dec.op   = OP_ILL;
      dec.len  = 3'd1;
      dec.disp = win[39:8];
      if (b0[7:3] == GRP_PUSH) begin
         dec.op  = OP_PUSH;
         dec.src = b0[2:0];
      end else if (b0[7:3] == GRP_POP) begin
         dec.op  = OP_POP;
         dec.dst = b0[2:0];
      end else if (b0 == BYTE_RET) begin
         dec.op  = OP_RET;
      end else if (b0 == BYTE_CALL) begin
         dec.op  = OP_CALL;
         dec.len = 3'd5;
      end else if (b0 == BYTE_WIDE && b1 == BYTE_MOV) begin
         dec.src = b2[5:3];
         dec.dst = b2[2:0];
         dec.len = 3'd3;
         if (b2[7:6] == 2'b11)      dec.op = OP_MOVR;
         else if (b2[7:6] == 2'b00) dec.op = OP_STORE;
         else begin
            dec.op  = OP_ILL;
            dec.len = 3'd1;
         end
      end
   end

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
   parameter int          NREG     = 8,
   parameter int          DATA_W   = 64,
   parameter int          SP_IDX   = 4,
   parameter logic [63:0] RESET_SP = 64'h300
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(NREG)-1:0] ra_idx,
   output logic [DATA_W-1:0]       ra_data,
   input  logic [$clog2(NREG)-1:0] rb_idx,
   output logic [DATA_W-1:0]       rb_data,
   output logic [DATA_W-1:0]       sp_data,
   input  logic                    sp_we,
   input  logic [DATA_W-1:0]       sp_wdata,
   input  logic                    gp_we,
   input  logic [$clog2(NREG)-1:0] gp_idx,
   input  logic [DATA_W-1:0]       gp_wdata
);

   localparam int IDX_W = $clog2(NREG);

   logic [NREG-1:0][DATA_W-1:0] rq;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [DATA_W-1:0] RV = (g == SP_IDX) ? RESET_SP[DATA_W-1:0] : '0;
      logic [DATA_W-1:0] q;
      // general write port wins over the stack-pointer port (pop into SP)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= RV;
         else if (gp_we && gp_idx == IDX_W'(g))   q <= gp_wdata;
         else if (sp_we && g == SP_IDX)           q <= sp_wdata;
      end
      assign rq[g] = q;
   end

   assign ra_data = rq[ra_idx];
   assign rb_data = rq[rb_idx];
   assign sp_data = rq[SP_IDX];

endmodule

// File: rtl/stk_npc.sv
module stk_npc
   import stk_core_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  op_e               op,
   input  logic [ADDR_W-1:0] pc,
   input  logic [2:0]        len,
   input  logic [31:0]       disp,
   input  logic [ADDR_W-1:0] popped,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] rel;

   assign seq_pc = pc + ADDR_W'(len);

   if (ADDR_W > 32) begin : g_sext
      assign rel = {{(ADDR_W-32){disp[31]}}, disp};
   end else begin : g_trunc
      assign rel = disp[ADDR_W-1:0];
   end

   always_comb begin
      case (op)
         OP_CALL: nxt = seq_pc + rel;
         OP_RET:  nxt = popped;
         default: nxt = seq_pc;
      endcase
   end

endmodule

// File: rtl/stk_core.sv
module stk_core
   import stk_core_pkg::*;
#(
   parameter int          ADDR_W   = 10,
   parameter int          DATA_W   = 64,
   parameter int          NREG     = 8,
   parameter int          SP_IDX   = 4,
   parameter logic [63:0] RESET_PC = 64'h0,
   parameter logic [63:0] RESET_SP = 64'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] cur_pc,
   output logic              halted
);

   localparam int             IDX_W  = $clog2(NREG);
   localparam int             WORD_B = DATA_W / 8;
   localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_B);

   if (DATA_W != 64) begin : g_bad_dw
      $error("stk_core: DATA_W must be 64");
   end
   if (NREG != 8) begin : g_bad_nreg
      $error("stk_core: NREG must be 8, register fields are 3 bits");
   end
   if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_bad_sp
      $error("stk_core: SP_IDX out of range");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("stk_core: ADDR_W must be 8..64");
   end

   st_e               state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [IR_W-1:0]   ir_q;
   dec_t              dec, dq;
   logic [DATA_W-1:0] val_q, val_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] spn_q, spn_d;
   logic [DATA_W-1:0] ld_q;
   logic [ADDR_W-1:0] npc;
   logic [DATA_W-1:0] ra_data, rb_data, sp_data;
   logic              mem_op;
   logic              wr_op;
   logic              sp_we, gp_we;
   logic [DATA_W-1:0] gp_wdata;

   stk_decode u_dec (
      .win (ir_q),
      .dec (dec)
   );

   stk_regs #(
      .NREG     (NREG),
      .DATA_W   (DATA_W),
      .SP_IDX   (SP_IDX),
      .RESET_SP (RESET_SP)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ra_idx   (IDX_W'(dec.src)),
      .ra_data  (ra_data),
      .rb_idx   (IDX_W'(dec.dst)),
      .rb_data  (rb_data),
      .sp_data  (sp_data),
      .sp_we    (sp_we),
      .sp_wdata (spn_q),
      .gp_we    (gp_we),
      .gp_idx   (IDX_W'(dq.dst)),
      .gp_wdata (gp_wdata)
   );

   stk_npc #(
      .ADDR_W (ADDR_W)
   ) u_npc (
      .op     (dq.op),
      .pc     (pc_q),
      .len    (dq.len),
      .disp   (dq.disp),
      .popped (ld_q[ADDR_W-1:0]),
      .nxt    (npc)
   );

   // operand and address preparation during decode
   always_comb begin
      val_d  = ra_data;
      addr_d = sp_data[ADDR_W-1:0];
      spn_d  = sp_data;
      case (dec.op)
         OP_PUSH: begin
            spn_d  = sp_data - STEP;
            addr_d = spn_d[ADDR_W-1:0];
         end
         OP_CALL: begin
            val_d  = DATA_W'(pc_q + ADDR_W'(dec.len));
            spn_d  = sp_data - STEP;
            addr_d = spn_d[ADDR_W-1:0];
         end
         OP_POP, OP_RET: begin
            spn_d  = sp_data + STEP;
         end
         OP_STORE: begin
            addr_d = rb_data[ADDR_W-1:0];
         end
         default: ;
      endcase
   end

   assign mem_op = (dq.op == OP_PUSH) || (dq.op == OP_POP) || (dq.op == OP_STORE) ||
                   (dq.op == OP_CALL) || (dq.op == OP_RET);
   assign wr_op  = (dq.op == OP_PUSH) || (dq.op == OP_STORE) || (dq.op == OP_CALL);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = pc_q;
      mem_wdata = val_q;
      if (state_q == S_FETCH) begin
         mem_req = 1'b1;
      end else if (state_q == S_EXEC && mem_op) begin
         mem_req  = 1'b1;
         mem_we   = wr_op;
         mem_addr = addr_q;
      end
   end

   assign sp_we    = (state_q == S_WB) &&
                     (dq.op == OP_PUSH || dq.op == OP_POP || dq.op == OP_CALL || dq.op == OP_RET);
   assign gp_we    = (state_q == S_WB) && (dq.op == OP_POP || dq.op == OP_MOVR);
   assign gp_wdata = (dq.op == OP_POP) ? ld_q : val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_FETCH;
         pc_q    <= RESET_PC[ADDR_W-1:0];
         ir_q    <= '0;
         dq      <= '0;
         val_q   <= '0;
         addr_q  <= '0;
         spn_q   <= '0;
         ld_q    <= '0;
      end else begin
         case (state_q)
            S_FETCH: begin
               if (mem_ready) begin
                  ir_q    <= mem_rdata[IR_W-1:0];
                  state_q <= S_DEC;
               end
            end
            S_DEC: begin
               if (dec.op == OP_ILL) begin
                  state_q <= S_HALT;
               end else begin
                  dq      <= dec;
                  val_q   <= val_d;
                  addr_q  <= addr_d;
                  spn_q   <= spn_d;
                  state_q <= S_EXEC;
               end
            end
            S_EXEC: begin
               if (!mem_op) begin
                  state_q <= S_WB;
               end else if (mem_ready) begin
                  ld_q    <= mem_rdata;
                  state_q <= S_WB;
               end
            end
            S_WB: begin
               pc_q    <= npc;
               state_q <= S_FETCH;
            end
            default: state_q <= S_HALT;
         endcase
      end
   end

   assign cur_pc = pc_q;
   assign halted = (state_q == S_HALT);

   // ---------------- assertions ----------------
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req);

   p_halt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(cur_pc)));

   p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && dq.op == OP_PUSH) |=> (sp_data == $past(sp_data) - STEP));

   p_pop_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && dq.op == OP_POP && dq.dst != 3'(SP_IDX)) |=> (sp_data == $past(sp_data) + STEP));

   p_ret_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && dq.op == OP_RET) |=> (cur_pc == $past(ld_q[ADDR_W-1:0])));

   p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DEC && dec.op != OP_ILL) |-> (dec.len == 3'd1 || dec.len == 3'd3 || dec.len == 3'd5));

   p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && (dq.op == OP_MOVR || dq.op == OP_STORE)) |=> (cur_pc == $past(cur_pc) + ADDR_W'(3)));

endmodule

// File: tb/stk_core_bench.sv
`timescale 1ns/1ps
module stk_core_bench;

   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 10;
   localparam int          MSZ        = 1 << AW;
   localparam logic [63:0] R_PC       = 64'h0;
   localparam logic [63:0] R_SP       = 64'h300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [63:0]   mem_wdata;
   logic [63:0]   mem_rdata = '0;
   logic          mem_ready = 1'b0;
   logic [AW-1:0] cur_pc;
   logic          halted;

   always #(CLK_PERIOD/2) clk = ~clk;

   stk_core #(
      .ADDR_W   (AW),
      .DATA_W   (64),
      .NREG     (8),
      .SP_IDX   (4),
      .RESET_PC (R_PC),
      .RESET_SP (R_SP)
   ) u_stk_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .cur_pc    (cur_pc),
      .halted    (halted)
   );

   typedef struct {
      bit            we;
      logic [AW-1:0] a;
      logic [63:0]   d;
      string         tag;
   } xact_t;

   xact_t         expq[$];
   logic [7:0]    bmem [MSZ];
   logic [7:0]    smem [MSZ];
   logic [63:0]   mreg [8];
   logic [AW-1:0] apc;
   logic [AW-1:0] halt_pc;
   int            nchk = 0;
   int            nfail = 0;
   int            seq = 0;
   int            wait_left = 0;
   bit            hold_v = 0;
   logic [AW-1:0] h_a;
   logic          h_we;
   logic [63:0]   h_d;

   // ---------------- memory model and monitor ----------------
   always @(negedge clk) begin
      mem_ready = 1'b0;
      if (rst_n && mem_req) begin
         if (hold_v) begin
            nchk++;
            if (mem_addr !== h_a || mem_we !== h_we || (h_we && mem_wdata !== h_d)) begin
               nfail++;
               $display("FAIL R10 request changed while waiting: addr %h we %b act, addr %h we %b exp",
                        mem_addr, mem_we, h_a, h_we);
            end
         end
         if (wait_left == 0) begin
            xact_t e;
            mem_ready = 1'b1;
            hold_v    = 0;
            for (int i = 0; i < 8; i++) mem_rdata[8*i +: 8] = bmem[AW'(mem_addr + AW'(i))];
            if (mem_we)
               for (int i = 0; i < 8; i++) bmem[AW'(mem_addr + AW'(i))] = mem_wdata[8*i +: 8];
            nchk++;
            if (expq.size() == 0) begin
               nfail++;
               $display("FAIL R9 unexpected transfer: we %b addr %h act, none exp", mem_we, mem_addr);
            end else begin
               e = expq.pop_front();
               if (mem_we !== e.we || mem_addr !== e.a || (e.we && mem_wdata !== e.d)) begin
                  nfail++;
                  $display("FAIL %s transfer: we %b addr %h data %h act, we %b addr %h data %h exp",
                           e.tag, mem_we, mem_addr, mem_wdata, e.we, e.a, e.d);
               end
            end
            seq++;
            wait_left = seq % 3;
         end else begin
            wait_left--;
            hold_v = 1;
            h_a    = mem_addr;
            h_we   = mem_we;
            h_d    = mem_wdata;
         end
      end else begin
         if (rst_n && hold_v) begin
            nchk++;
            nfail++;
            $display("FAIL R10 request dropped: req %b act, 1 exp", mem_req);
         end
         hold_v = 0;
      end
   end

   // ---------------- reference model / driver ----------------
   function automatic logic [63:0] sh64(input logic [AW-1:0] a);
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = smem[AW'(a + AW'(i))];
      return v;
   endfunction

   task automatic put_b(input logic [7:0] b);
      bmem[apc] = b;
      smem[apc] = b;
      apc = apc + 1'b1;
   endtask

   task automatic exp_rd(input logic [AW-1:0] a, input string tag);
      xact_t e;
      e.we = 0; e.a = a; e.d = '0; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic exp_wr(input logic [AW-1:0] a, input logic [63:0] d, input string tag);
      xact_t e;
      e.we = 1; e.a = a; e.d = d; e.tag = tag;
      expq.push_back(e);
      for (int i = 0; i < 8; i++) smem[AW'(a + AW'(i))] = d[8*i +: 8];
   endtask

   task automatic i_push(input int r, input string tag);
      logic [AW-1:0] p = apc;
      logic [63:0]   v = mreg[r];
      logic [63:0]   s = mreg[4] - 64'd8;
      put_b(8'h50 + 8'(r));
      exp_rd(p, "R2");
      exp_wr(s[AW-1:0], v, tag);
      mreg[4] = s;
   endtask

   task automatic i_pop(input int r, input string tag);
      logic [AW-1:0] p = apc;
      logic [AW-1:0] a = mreg[4][AW-1:0];
      put_b(8'h58 + 8'(r));
      exp_rd(p, "R2");
      exp_rd(a, tag);
      mreg[4] = mreg[4] + 64'd8;
      mreg[r] = sh64(a);
   endtask

   task automatic i_mov(input int s, input int d);
      logic [AW-1:0] p = apc;
      put_b(8'h48); put_b(8'h89); put_b({2'b11, 3'(s), 3'(d)});
      exp_rd(p, "R2");
      mreg[d] = mreg[s];
   endtask

   task automatic i_st(input int s, input int b);
      logic [AW-1:0] p = apc;
      put_b(8'h48); put_b(8'h89); put_b({2'b00, 3'(s), 3'(b)});
      exp_rd(p, "R2");
      exp_wr(mreg[b][AW-1:0], mreg[s], "R6");
   endtask

   task automatic i_call(input logic [31:0] disp);
      logic [AW-1:0] p   = apc;
      logic [AW-1:0] ret = apc + AW'(5);
      logic [63:0]   s   = mreg[4] - 64'd8;
      put_b(8'hE8);
      for (int i = 0; i < 4; i++) put_b(disp[8*i +: 8]);
      exp_rd(p, "R2");
      exp_wr(s[AW-1:0], 64'(ret), "R7");
      mreg[4] = s;
      apc = ret + disp[AW-1:0];
   endtask

   task automatic i_ret();
      logic [AW-1:0] p = apc;
      logic [AW-1:0] a = mreg[4][AW-1:0];
      logic [63:0]   v;
      put_b(8'hC3);
      exp_rd(p, "R2");
      exp_rd(a, "R8");
      v = sh64(a);
      mreg[4] = mreg[4] + 64'd8;
      apc = v[AW-1:0];
   endtask

   task automatic i_bad(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      logic [AW-1:0] p = apc;
      put_b(b0); put_b(b1); put_b(b2);
      exp_rd(p, "R9");
      halt_pc = p;
   endtask

   task automatic wr_pre(input logic [AW-1:0] a, input logic [63:0] d);
      for (int i = 0; i < 8; i++) begin
         bmem[AW'(a + AW'(i))] = d[8*i +: 8];
         smem[AW'(a + AW'(i))] = d[8*i +: 8];
      end
   endtask

   task automatic prep();
      for (int i = 0; i < MSZ; i++) begin bmem[i] = 8'h00; smem[i] = 8'h00; end
      wr_pre(10'h300, 64'h1122334455667788);
      wr_pre(10'h308, 64'hDEADBEEF0BADF00D);
      wr_pre(10'h310, 64'h0123456789ABCDEF);
      wr_pre(10'h318, 64'h00000000000001F0);
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      mreg[4] = R_SP;
      apc = R_PC[AW-1:0];
      expq.delete();
   endtask

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: %h act, %h exp", what, act, exp);
      end
   endtask

   task automatic run_prog();
      bit done = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(halted === 1'b0, "R1 halted in reset", 64'(halted), 64'd0);
      check(cur_pc === R_PC[AW-1:0], "R1 pc in reset", 64'(cur_pc), R_PC);
      rst_n = 1'b1;
      for (int n = 0; n < 4000 && !done; n++) begin
         @(negedge clk);
         if (halted === 1'b1) done = 1;
      end
      check(done, "R9 core reached halt", 64'(halted), 64'd1);
      check(cur_pc === halt_pc, "R9 pc at illegal instruction", 64'(cur_pc), 64'(halt_pc));
      for (int n = 0; n < 8; n++) begin
         @(negedge clk);
         check(mem_req === 1'b0, "R9 no request while halted", 64'(mem_req), 64'd0);
         check(cur_pc === halt_pc, "R9 pc frozen", 64'(cur_pc), 64'(halt_pc));
      end
      check(expq.size() == 0, "R9 all expected transfers seen", 64'(expq.size()), 64'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      nfail++;
      $display("FAIL R9 watchdog expired: running act, finished exp");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   // ---------------- programs ----------------
   initial begin
      // program 1: stack, moves, store, nested calls, SP corner cases
      prep();
      i_push(0, "R1");            // zero register, first write at RESET_SP-8
      i_pop(7, "R4");
      i_pop(1, "R4");
      i_pop(2, "R4");
      i_pop(3, "R4");
      i_mov(2, 5);                // R5
      i_push(5, "R5");
      i_pop(6, "R4");
      i_pop(0, "R4");             // r0 = 0x1F0, store base
      i_st(1, 0);                 // R6
      i_push(4, "R3");            // pre-decrement SP value stored
      i_call(32'h0000_0100);      // R7 forward
      i_push(3, "R3");
      i_call(32'hFFFF_FF80);      // R7 backward, nested
      i_mov(3, 1);
      i_ret();                    // R8
      i_pop(2, "R4");
      i_ret();                    // R8
      i_push(2, "R3");
      i_pop(4, "R4");             // load wins over increment
      i_push(4, "R4");
      i_st(6, 0);                 // R6
      i_push(1, "R5");            // r1 was overwritten by the move in the nested routine
      i_bad(8'hFF, 8'h00, 8'h00); // R9 bad first byte
      run_prog();

      // program 2: mode field 01 is illegal
      prep();
      i_pop(5, "R4");
      i_mov(5, 3);
      i_push(3, "R5");
      i_bad(8'h48, 8'h89, 8'h48); // R9
      run_prog();

      // program 3: wide prefix with wrong opcode
      prep();
      i_push(1, "R1");
      i_bad(8'h48, 8'h8B, 8'hC0); // R9
      run_prog();

      // program 4: call wrapping below address zero, then mode 10
      prep();
      i_call(32'hFFFF_FE00);      // R7 wrap
      i_push(4, "R3");
      i_bad(8'h48, 8'h89, 8'h88); // R9
      run_prog();

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule